// File: doc/BRIEF.md
# Pseudo-Associative Cache Lookup Controller

This block runs lookups into a direct-mapped line array so that the array behaves much like a two-way cache. Each set has a partner set whose index is the same value with the top index bit inverted. Together the two sets form a pair of slots for one address. A request compares its tag against its own (primary) slot first. If that fails, it compares against the partner (alternate) slot in the following cycle. A match on the first compare is reported as a fast hit. A match on the second compare is reported as a slow hit.

A slow hit exchanges the contents of the two slots, so that the recently used line sits where the next lookup will find it first. When neither slot matches, the controller requests the line from memory. It writes the returned word into the primary slot and pushes the previous primary line into the alternate slot.

The tag and data storage sits inside the block as register arrays. Each entry keeps the tag together with its home index bit, so that a line parked in its partner's slot can never be mistaken for a line of that partner. The block handles read lookups only.

Top module: `psa_cache_lookup`

## Requirements
- R1: While reset is applied and after it is released, `rsp_valid` and `mem_req` are 0, `req_ready` is 1, and every line is invalid, so the first lookup of any address is a miss.
- R2: A request whose address is held in its primary slot (index = `req_addr[IDX_W-1:0]`) returns `rsp_kind` = 2'b01 (fast) and that line's data, with `rsp_valid` high in the cycle after the acceptance cycle.
- R3: A request that fails in the primary slot but matches in the alternate slot (primary index with its top bit inverted) returns `rsp_kind` = 2'b10 (slow), two cycles after acceptance.
- R4: A slow hit exchanges the primary and alternate lines: the same address then hits fast, and the line that was primary before then hits slow.
- R5: When both slots fail, `mem_req` rises two cycles after acceptance with `mem_addr` equal to the request address, and stays high with a stable address until `mem_ack`. The response `rsp_kind` = 2'b11 (miss) carries `mem_rdata` and appears in the cycle after `mem_ack`.
- R6: A fill places the new line in the primary slot, moves the old primary line to the alternate slot, and drops the old alternate line.
- R7: `req_ready` is 1 only when no lookup is in progress. A request presented while `req_ready` is 0 is not taken and produces no response and no change to the lines.
- R8: `rsp_valid` is a single-cycle pulse, and `rsp_kind` is never 2'b00 while it is high.
- R9: A match needs the full address. A line that sits in the probed slot but belongs to the partner index, even with equal upper address bits, does not hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Controller idle, request taken this cycle |
| req_addr | input | ADDR_W | Word address of the lookup |
| rsp_valid | output | 1 | Response pulse |
| rsp_kind | output | 2 | 01 fast hit, 10 slow hit, 11 miss |
| rsp_data | output | DATA_W | Line data returned |
| mem_req | output | 1 | Line fetch request to memory |
| mem_addr | output | ADDR_W | Address of the fetch |
| mem_ack | input | 1 | Memory returns the fetched word this cycle |
| mem_rdata | input | DATA_W | Fetched word |

## Verification
The bench builds the block with ADDR_W = 8, IDX_W = 3 and DATA_W = 16. This gives four slot pairs and a tag of five bits, so a handful of addresses is enough to fill both slots of a pair, force evictions, and bring two addresses that differ only in the top index bit into the same slot pair. With a three-cycle memory model, the fast, slow and miss latencies are all distinct. A pseudo-random run over a small address pool then mixes every kind of response with repeated swaps and evictions.

// File: rtl/psa_pkg.sv
package psa_pkg;

  // Response classification, also the encoding driven on rsp_kind.
  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_FAST = 2'd1,
    KIND_SLOW = 2'd2,
    KIND_MISS = 2'd3
  } hit_kind_e;

  // Lookup sequencer states.
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2,
    ST_FILL   = 2'd3
  } probe_state_e;

endpackage

// File: rtl/psa_slot_map.sv
// Maps a request index to its home slot and to the partner slot of its pair.
module psa_slot_map #(
  parameter int IDX_W = 4
) (
  input  logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] prim_slot,
  output logic [IDX_W-1:0] alt_slot
);
  localparam int TOP = IDX_W - 1;

  assign prim_slot = idx;

  generate
    if (IDX_W == 1) begin : g_single
      assign alt_slot = ~idx;
    end else begin : g_multi
      assign alt_slot = {~idx[TOP], idx[TOP-1:0]};
    end
  endgenerate
endmodule

// File: rtl/psa_line_store.sv
// Line array: two read ports and two write ports that update together.
module psa_line_store #(
  parameter int IDX_W  = 4,
  parameter int KEY_W  = 9,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_a_idx,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic              a_valid,
  output logic [KEY_W-1:0]  a_key,
  output logic [DATA_W-1:0] a_data,
  output logic              b_valid,
  output logic [KEY_W-1:0]  b_key,
  output logic [DATA_W-1:0] b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_a_idx,
  input  logic              wr_a_valid,
  input  logic [KEY_W-1:0]  wr_a_key,
  input  logic [DATA_W-1:0] wr_a_data,
  input  logic [IDX_W-1:0]  wr_b_idx,
  input  logic              wr_b_valid,
  input  logic [KEY_W-1:0]  wr_b_key,
  input  logic [DATA_W-1:0] wr_b_data
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0]   valid_q;
  logic [KEY_W-1:0]  key_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS];

  // Valid bits are the only reset state of the array.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_a_idx] <= wr_a_valid;
      valid_q[wr_b_idx] <= wr_b_valid;
    end
  end

  // Payload has no reset; it is qualified by valid_q.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      key_q[wr_a_idx]  <= wr_a_key;
      data_q[wr_a_idx] <= wr_a_data;
      key_q[wr_b_idx]  <= wr_b_key;
      data_q[wr_b_idx] <= wr_b_data;
    end
  end

  assign a_valid = valid_q[rd_a_idx];
  assign a_key   = key_q[rd_a_idx];
  assign a_data  = data_q[rd_a_idx];
  assign b_valid = valid_q[rd_b_idx];
  assign b_key   = key_q[rd_b_idx];
  assign b_data  = data_q[rd_b_idx];
endmodule

// File: rtl/psa_tag_match.sv
// The single tag comparator, shared by both probes.
module psa_tag_match #(
  parameter int KEY_W = 9
) (
  input  logic             line_valid,
  input  logic [KEY_W-1:0] line_key,
  input  logic [KEY_W-1:0] want_key,
  output logic             hit
);
  assign hit = line_valid && (line_key == want_key);
endmodule

// File: rtl/psa_probe_fsm.sv
// Sequencer: primary probe, alternate probe, then memory fill.
module psa_probe_fsm
  import psa_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_valid,
  input  logic      hit,
  input  logic      mem_ack,
  output logic      req_ready,
  output logic      accept,
  output logic      probe_second,
  output logic      swap_en,
  output logic      fill_en,
  output logic      rsp_set,
  output hit_kind_e rsp_kind_d,
  output logic      mem_req
);
  probe_state_e state_q, state_d;
  logic         mreq_q, mreq_d;

  always_comb begin
    state_d      = state_q;
    mreq_d       = mreq_q;
    req_ready    = 1'b0;
    accept       = 1'b0;
    probe_second = 1'b0;
    swap_en      = 1'b0;
    fill_en      = 1'b0;
    rsp_set      = 1'b0;
    rsp_kind_d   = KIND_NONE;
    case (state_q)
      ST_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) begin
          accept  = 1'b1;
          state_d = ST_FIRST;
        end
      end
      ST_FIRST: begin
        if (hit) begin
          rsp_set    = 1'b1;
          rsp_kind_d = KIND_FAST;
          state_d    = ST_IDLE;
        end else begin
          state_d = ST_SECOND;
        end
      end
      ST_SECOND: begin
        probe_second = 1'b1;
        if (hit) begin
          rsp_set    = 1'b1;
          rsp_kind_d = KIND_SLOW;
          swap_en    = 1'b1;
          state_d    = ST_IDLE;
        end else begin
          mreq_d  = 1'b1;
          state_d = ST_FILL;
        end
      end
      ST_FILL: begin
        if (mem_ack) begin
          fill_en    = 1'b1;
          rsp_set    = 1'b1;
          rsp_kind_d = KIND_MISS;
          mreq_d     = 1'b0;
          state_d    = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mreq_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      mreq_q  <= mreq_d;
    end
  end

  assign mem_req = mreq_q;
endmodule

// File: rtl/psa_cache_lookup.sv
module psa_cache_lookup
  import psa_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [1:0]        rsp_kind,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  // Key = tag plus the top index bit, so a line parked in its partner's
  // slot stays distinguishable from the partner's own lines.
  localparam int KEY_W = ADDR_W - IDX_W + 1;

  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta_q, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  // Request capture
  logic              accept;
  logic [ADDR_W-1:0] addr_q;
  always_ff @(posedge clk) begin
    if (accept) addr_q <= req_addr;
  end

  logic [IDX_W-1:0] idx_q;
  logic [KEY_W-1:0] key_req;
  assign idx_q   = addr_q[IDX_W-1:0];
  assign key_req = addr_q[ADDR_W-1:IDX_W-1];

  logic [IDX_W-1:0] prim_slot, alt_slot;
  psa_slot_map #(.IDX_W(IDX_W)) u_map (
    .idx       (idx_q),
    .prim_slot (prim_slot),
    .alt_slot  (alt_slot)
  );

  // Line array
  logic              a_valid, b_valid;
  logic [KEY_W-1:0]  a_key, b_key;
  logic [DATA_W-1:0] a_data, b_data;
  logic              wr_en, wr_a_valid, wr_b_valid;
  logic [KEY_W-1:0]  wr_a_key, wr_b_key;
  logic [DATA_W-1:0] wr_a_data, wr_b_data;
  logic              swap_en, fill_en;

  psa_line_store #(.IDX_W(IDX_W), .KEY_W(KEY_W), .DATA_W(DATA_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .rd_a_idx   (prim_slot),
    .rd_b_idx   (alt_slot),
    .a_valid    (a_valid),
    .a_key      (a_key),
    .a_data     (a_data),
    .b_valid    (b_valid),
    .b_key      (b_key),
    .b_data     (b_data),
    .wr_en      (wr_en),
    .wr_a_idx   (prim_slot),
    .wr_a_valid (wr_a_valid),
    .wr_a_key   (wr_a_key),
    .wr_a_data  (wr_a_data),
    .wr_b_idx   (alt_slot),
    .wr_b_valid (wr_b_valid),
    .wr_b_key   (wr_b_key),
    .wr_b_data  (wr_b_data)
  );

  // One comparator, steered to the slot being probed.
  logic             probe_second, hit;
  logic             cmp_valid;
  logic [KEY_W-1:0] cmp_key;
  assign cmp_valid = probe_second ? b_valid : a_valid;
  assign cmp_key   = probe_second ? b_key   : a_key;

  psa_tag_match #(.KEY_W(KEY_W)) u_match (
    .line_valid (cmp_valid),
    .line_key   (cmp_key),
    .want_key   (key_req),
    .hit        (hit)
  );

  // Sequencer
  logic      rsp_set;
  hit_kind_e rsp_kind_d;
  psa_probe_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .req_valid    (req_valid),
    .hit          (hit),
    .mem_ack      (mem_ack),
    .req_ready    (req_ready),
    .accept       (accept),
    .probe_second (probe_second),
    .swap_en      (swap_en),
    .fill_en      (fill_en),
    .rsp_set      (rsp_set),
    .rsp_kind_d   (rsp_kind_d),
    .mem_req      (mem_req)
  );

  // Write steering: the alternate slot always receives the old primary line;
  // the primary slot receives either the old alternate line or the fill.
  always_comb begin
    wr_en      = swap_en | fill_en;
    wr_b_valid = a_valid;
    wr_b_key   = a_key;
    wr_b_data  = a_data;
    if (fill_en) begin
      wr_a_valid = 1'b1;
      wr_a_key   = key_req;
      wr_a_data  = mem_rdata;
    end else begin
      wr_a_valid = b_valid;
      wr_a_key   = b_key;
      wr_a_data  = b_data;
    end
  end

  // Response registers
  logic [DATA_W-1:0] rsp_data_d;
  always_comb begin
    case (rsp_kind_d)
      KIND_FAST: rsp_data_d = a_data;
      KIND_SLOW: rsp_data_d = b_data;
      default:   rsp_data_d = mem_rdata;
    endcase
  end

  logic              rsp_valid_q;
  hit_kind_e         rsp_kind_q;
  logic [DATA_W-1:0] rsp_data_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      rsp_valid_q <= 1'b0;
      rsp_kind_q  <= KIND_NONE;
    end else begin
      rsp_valid_q <= rsp_set;
      if (rsp_set) rsp_kind_q <= rsp_kind_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rsp_set) rsp_data_q <= rsp_data_d;
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_kind  = rsp_kind_q;
  assign rsp_data  = rsp_data_q;
  assign mem_addr  = addr_q;
endmodule

// File: rtl/psa_cache_chk.sv
module psa_cache_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [1:0]        rsp_kind,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack
);
  // R1: quiet outputs while reset is held
  p_rst_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!rsp_valid && !mem_req));

  // R2: fast response follows acceptance by one cycle
  p_fast_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == 2'b01) |-> $past(req_valid && req_ready, 2));

  // R3: slow response follows acceptance by two cycles
  p_slow_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == 2'b10) |-> $past(req_valid && req_ready, 3));

  // R5: fetch request held with a steady address until acknowledged
  p_mreq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R5: miss response only right after the memory handshake
  p_miss_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == 2'b11) |-> $past(mem_req && mem_ack));

  // R7: no new request taken while a fetch is outstanding
  p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

  // R8: response is a single pulse with a defined kind
  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_kind != 2'b00));
endmodule

bind psa_cache_lookup psa_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_kind  (rsp_kind),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .mem_ack   (mem_ack)
);

// File: tb/sim_psa_cache_lookup.sv
`timescale 1ns/1ps
module sim_psa_cache_lookup;
  localparam int AW = 8;
  localparam int IW = 3;
  localparam int DW = 16;
  localparam int SETS = 1 << IW;
  localparam int MEM_LAT = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [AW-1:0] req_addr;
  logic          rsp_valid;
  logic [1:0]    rsp_kind;
  logic [DW-1:0] rsp_data;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_ack;
  logic [DW-1:0] mem_rdata;

  always #2.5 clk = ~clk;

  psa_cache_lookup #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
    .rsp_data(rsp_data), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
    return DW'(a * 16'd97 + 16'h01c3);
  endfunction

  // Scoreboard
  typedef struct {
    logic [1:0]    kind;
    logic [DW-1:0] data;
    int            acc;
    string         rq;
  } exp_t;
  exp_t sb[$];

  // Reference slot contents, kept from the requirements
  logic [AW-1:0] ma [SETS];
  bit            mv [SETS];
  logic [AW-1:0] last_addr;
  int            last_acc;

  task automatic do_req(input logic [AW-1:0] a, input string rq);
    exp_t e;
    int p, q;
    logic [AW-1:0] t;
    bit tv;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    p = int'(a[IW-1:0]);
    q = p ^ (1 << (IW-1));
    if (mv[p] && ma[p] == a) begin
      e.kind = 2'b01;
    end else if (mv[q] && ma[q] == a) begin
      e.kind = 2'b10;
      t = ma[p]; tv = mv[p];
      ma[p] = ma[q]; mv[p] = mv[q];
      ma[q] = t; mv[q] = tv;
    end else begin
      e.kind = 2'b11;
      ma[q] = ma[p]; mv[q] = mv[p];
      ma[p] = a; mv[p] = 1'b1;
    end
    e.data = word_of(a);
    e.rq   = rq;
    req_valid = 1'b1;
    req_addr  = a;
    last_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    e.acc    = cyc;
    last_acc = cyc;
    sb.push_back(e);
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R7", "unexpected response", 1, 0);
      end else begin
        exp_t e;
        int lat;
        e = sb.pop_front();
        lat = (e.kind == 2'b01) ? 1 : (e.kind == 2'b10) ? 2 : 3 + MEM_LAT;
        check(rsp_kind == e.kind, e.rq, "kind", int'(rsp_kind), int'(e.kind));
        check(rsp_data == e.data, e.rq, "data", int'(rsp_data), int'(e.data));
        check(cyc - e.acc == lat, e.rq, "latency", cyc - e.acc, lat);
      end
    end
  end

  // Memory model
  initial begin
    mem_ack   = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_req) begin
        check(mem_addr == last_addr, "R5", "mem_addr", int'(mem_addr), int'(last_addr));
        check(cyc - last_acc == 2, "R5", "mem_req delay", cyc - last_acc, 2);
        repeat (MEM_LAT) @(negedge clk);
        check(mem_req == 1'b1, "R5", "mem_req held", int'(mem_req), 1);
        mem_ack   = 1'b1;
        mem_rdata = word_of(mem_addr);
        @(negedge clk);
        mem_ack   = 1'b0;
        mem_rdata = '0;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] lf;
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_addr  = '0;
    for (int i = 0; i < SETS; i++) begin
      mv[i] = 1'b0;
      ma[i] = '0;
    end
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R1", "rsp_valid in reset", int'(rsp_valid), 0);
    check(mem_req == 1'b0, "R1", "mem_req in reset", int'(mem_req), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
    check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", int'(rsp_valid), 0);

    // Slot pair {1,5}
    do_req(8'h11, "R1");   // all lines invalid: miss
    do_req(8'h11, "R2");   // fast
    do_req(8'h21, "R5");   // miss; 11 moves to slot 5
    do_req(8'h21, "R2");   // fast
    do_req(8'h11, "R3");   // found in slot 5: slow, swap
    do_req(8'h11, "R4");   // now fast
    do_req(8'h21, "R4");   // former primary: slow, swap back
    do_req(8'h31, "R6");   // fill: 31 primary, 21 alternate, 11 dropped
    do_req(8'h21, "R6");   // old primary found in alternate: slow
    do_req(8'h11, "R6");   // dropped line: miss
    do_req(8'h15, "R9");   // slot 1 holds 11, same upper bits: must miss
    do_req(8'h15, "R9");   // then fast

    // R7: request held while busy is not taken
    do_req(8'h46, "R7");
    check(req_ready == 1'b0, "R7", "req_ready while busy", int'(req_ready), 0);
    req_valid = 1'b1;
    req_addr  = 8'h56;
    repeat (2) @(negedge clk);
    req_valid = 1'b0;
    do_req(8'h46, "R7");   // still only its own line present: fast
    do_req(8'h56, "R7");   // never taken before: miss

    // Mixed run over a small pool
    lf = 8'h5b;
    for (int n = 0; n < 300; n++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      do_req({3'b000, lf[4:3], lf[2:0]}, "R4");
    end

    repeat (12) @(negedge clk);
    check(sb.size() == 0, "R8", "responses outstanding", sb.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule